// File: doc/BRIEF.md
# Buffered PWM Compare Reload Controller

This block keeps the seven timing values of a three-phase triangular-wave PWM timer: the carrier period, the duty compare values of phases U, V and W, a culling ratio, and two A/D trigger positions. Each value has a shadow copy that software writes and an active copy that the timer uses. The block has its own 16-bit carrier counter. The counter rises from 0001H to the active period, then falls back to 0001H, and repeats. The block flags the top of this ramp as a crest and the bottom as a valley.

The mode register sets how shadow values reach the active copies. In immediate mode a written value becomes active on the next clock. In the two batch modes the shadows are collected and moved over all at once. A write to the phase-U duty register arms this move. The move then happens at the next crest or valley, or only at the crest and valley events that survive culling. A culling ratio of N keeps one event out of every N+1.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset, every shadow and active register reads 0, except the period register, which reads FFFFH. The counter is 0001H and counting up. The mode register reads 1, which selects immediate mode.
- R2: In immediate mode (mode bit 0 = 1), a write to any buffered register shows on its active output one clock later. The culled-reload bit (mode bit 1) has no effect in this mode.
- R3: Register map, by write and read address: 0 period, 1 duty U, 2 duty V, 3 duty W, 4 culling ratio (bits 4:0), 5 A/D trigger A, 6 A/D trigger B, 7 mode (bit 0 immediate, bit 1 culled reload). Reads are combinational and return shadow values, not active values.
- R4: In a batch mode (mode bit 0 = 0), a write to address 1 arms a transfer. At the next transfer point, all seven active outputs take their shadow values on the same clock. The `xfer` output pulses in the cycle before that clock, and it is high only at a crest or valley.
- R5: In a batch mode, while nothing is armed, writes to the shadows never change any active output.
- R6: A crest is flagged while the counter equals the active period. A valley is flagged while the counter equals 0001H. The count direction turns down after a crest and turns up after a valley.
- R7: `cull_evt` marks one crest or valley event out of every N+1, where N is the active culling ratio. With N = 0, every event is marked.
- R8: With mode bit 1 = 1 in batch mode, a transfer happens only on an event marked by `cull_evt`. With mode bit 1 = 0, every crest and every valley is a transfer point.
- R9: If address 1 is written in the same cycle as a transfer, the transfer uses the old shadow value, and the block stays armed for the next transfer point.
- R10: Selecting immediate mode clears any pending arm, one cycle after the mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Shadow or mode read data |
| act_period | output | 16 | Active carrier period |
| act_duty_u | output | 16 | Active phase U compare |
| act_duty_v | output | 16 | Active phase V compare |
| act_duty_w | output | 16 | Active phase W compare |
| act_cull | output | 16 | Active culling ratio register |
| act_adc_a | output | 16 | Active A/D trigger position A |
| act_adc_b | output | 16 | Active A/D trigger position B |
| cnt_value | output | 16 | Carrier counter value |
| cnt_down | output | 1 | Counter is counting down |
| crest | output | 1 | Counter equals active period |
| valley | output | 1 | Counter equals 0001H |
| cull_evt | output | 1 | Event surviving culling |
| xfer | output | 1 | Batch transfer occurs at the coming edge |
| armed | output | 1 | Batch transfer pending |

## Verification
A phase-U write and a batch transfer can land in the same clock. The bench waits for a cycle where `xfer` is high and drives a new phase-U value in that exact cycle. It then expects the active output to carry the earlier shadow value while `armed` stays high. At the following transfer point it expects the new value to arrive. A mode switch to immediate while the block is armed is the other collision. It is judged by `armed` dropping and by no transfer afterwards.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

   localparam int NUM_BUF    = 7;
   localparam int REG_PERIOD = 0;
   localparam int REG_DUTY_U = 1;
   localparam int REG_DUTY_V = 2;
   localparam int REG_DUTY_W = 3;
   localparam int REG_CULL   = 4;
   localparam int REG_ADC_A  = 5;
   localparam int REG_ADC_B  = 6;
   localparam int REG_MODE   = 7;

   typedef enum logic [1:0] {
      UPD_IMMEDIATE    = 2'd0,
      UPD_BATCH        = 2'd1,
      UPD_BATCH_CULLED = 2'd2
   } upd_mode_e;

   function automatic upd_mode_e decode_mode(input logic imm_sel, input logic cull_en);
      if (imm_sel)      return UPD_IMMEDIATE;
      else if (cull_en) return UPD_BATCH_CULLED;
      else              return UPD_BATCH;
   endfunction

endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
   import pwm_reload_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 3,
   parameter int PERIOD_IDX = REG_PERIOD
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic                             imm_mode,
   input  logic                             xfer,
   output logic [NUM_BUF-1:0][DATA_W-1:0]   shadow_o,
   output logic [NUM_BUF-1:0][DATA_W-1:0]   active_o
);

   for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
      localparam logic [DATA_W-1:0] RST_VAL = (g == PERIOD_IDX) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
      logic              hit;
      logic [DATA_W-1:0] shadow_q;
      logic [DATA_W-1:0] active_q;

      assign hit = wr_en && (wr_addr == ADDR_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow_q <= RST_VAL;
            active_q <= RST_VAL;
         end else begin
            if (hit) shadow_q <= wr_data;
            if (imm_mode && hit) active_q <= wr_data;
            else if (xfer)       active_q <= shadow_q;
         end
      end

      assign shadow_o[g] = shadow_q;
      assign active_o[g] = active_q;
   end

endmodule

// File: rtl/pwm_tri_counter.sv
module pwm_tri_counter #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] period,
   output logic [DATA_W-1:0] cnt_o,
   output logic              down_o,
   output logic              crest_o,
   output logic              valley_o
);

   localparam logic [DATA_W-1:0] BOTTOM = DATA_W'(1);
   localparam logic [DATA_W-1:0] STEP   = DATA_W'(1);

   logic [DATA_W-1:0] cnt_q;
   logic              down_q;

   assign crest_o  = (cnt_q == period);
   assign valley_o = (cnt_q == BOTTOM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= BOTTOM;
         down_q <= 1'b0;
      end else if (crest_o && valley_o) begin
         cnt_q  <= cnt_q;
         down_q <= 1'b0;
      end else if (crest_o) begin
         cnt_q  <= cnt_q - STEP;
         down_q <= 1'b1;
      end else if (valley_o) begin
         cnt_q  <= cnt_q + STEP;
         down_q <= 1'b0;
      end else begin
         cnt_q  <= down_q ? cnt_q - STEP : cnt_q + STEP;
      end
   end

   assign cnt_o  = cnt_q;
   assign down_o = down_q;

endmodule

// File: rtl/pwm_event_cull.sv
module pwm_event_cull #(
   parameter int CULL_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              event_i,
   input  logic [CULL_W-1:0] ratio_i,
   output logic              pass_o
);

   logic [CULL_W-1:0] skip_q;

   assign pass_o = event_i && (skip_q >= ratio_i);

   always_ff @(posedge clk) begin
      if (!rst_n)       skip_q <= '0;
      else if (pass_o)  skip_q <= '0;
      else if (event_i) skip_q <= skip_q + CULL_W'(1);
   end

endmodule

// File: rtl/pwm_reload_arm.sv
module pwm_reload_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic batch_mode,
   input  logic arm_wr,
   input  logic point_i,
   output logic armed_o,
   output logic xfer_o
);

   logic armed_q;

   assign xfer_o = armed_q && point_i;

   always_ff @(posedge clk) begin
      if (!rst_n)          armed_q <= 1'b0;
      else if (!batch_mode) armed_q <= 1'b0;
      else                 armed_q <= arm_wr || (armed_q && !xfer_o);
   end

   assign armed_o = armed_q;

endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
   import pwm_reload_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3,
   parameter int CULL_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] act_period,
   output logic [DATA_W-1:0] act_duty_u,
   output logic [DATA_W-1:0] act_duty_v,
   output logic [DATA_W-1:0] act_duty_w,
   output logic [DATA_W-1:0] act_cull,
   output logic [DATA_W-1:0] act_adc_a,
   output logic [DATA_W-1:0] act_adc_b,
   output logic [DATA_W-1:0] cnt_value,
   output logic              cnt_down,
   output logic              crest,
   output logic              valley,
   output logic              cull_evt,
   output logic              xfer,
   output logic              armed
);

   localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(REG_MODE);
   localparam logic [ADDR_W-1:0] ARM_ADDR  = ADDR_W'(REG_DUTY_U);

   if (NUM_BUF >= (1 << ADDR_W)) begin : g_addr_check
      $error("ADDR_W too small for buffered registers plus mode register");
   end
   if (CULL_W > DATA_W || CULL_W < 1) begin : g_cull_check
      $error("CULL_W must be between 1 and DATA_W");
   end
   if (DATA_W < 2) begin : g_data_check
      $error("DATA_W must be at least 2");
   end

   logic                           imm_q;
   logic                           cull_en_q;
   upd_mode_e                      mode;
   logic [NUM_BUF-1:0][DATA_W-1:0] shadow_vec;
   logic [NUM_BUF-1:0][DATA_W-1:0] act_vec;
   logic                           evt;
   logic                           point;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imm_q     <= 1'b1;
         cull_en_q <= 1'b0;
      end else if (wr_en && wr_addr == MODE_ADDR) begin
         imm_q     <= wr_data[0];
         cull_en_q <= wr_data[1];
      end
   end

   assign mode = decode_mode(imm_q, cull_en_q);

   pwm_shadow_bank #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .PERIOD_IDX (REG_PERIOD)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .imm_mode (mode == UPD_IMMEDIATE),
      .xfer     (xfer),
      .shadow_o (shadow_vec),
      .active_o (act_vec)
   );

   pwm_tri_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .period   (act_vec[REG_PERIOD]),
      .cnt_o    (cnt_value),
      .down_o   (cnt_down),
      .crest_o  (crest),
      .valley_o (valley)
   );

   assign evt = crest || valley;

   pwm_event_cull #(.CULL_W(CULL_W)) u_cull (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_i (evt),
      .ratio_i (act_vec[REG_CULL][CULL_W-1:0]),
      .pass_o  (cull_evt)
   );

   always_comb begin
      unique case (mode)
         UPD_BATCH:        point = evt;
         UPD_BATCH_CULLED: point = cull_evt;
         default:          point = 1'b0;
      endcase
   end

   pwm_reload_arm u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .batch_mode (mode != UPD_IMMEDIATE),
      .arm_wr     (wr_en && wr_addr == ARM_ADDR),
      .point_i    (point),
      .armed_o    (armed),
      .xfer_o     (xfer)
   );

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_BUF; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_data = shadow_vec[i];
      end
      if (rd_addr == MODE_ADDR) rd_data = {{(DATA_W-2){1'b0}}, cull_en_q, imm_q};
   end

   assign act_period = act_vec[REG_PERIOD];
   assign act_duty_u = act_vec[REG_DUTY_U];
   assign act_duty_v = act_vec[REG_DUTY_V];
   assign act_duty_w = act_vec[REG_DUTY_W];
   assign act_cull   = act_vec[REG_CULL];
   assign act_adc_a  = act_vec[REG_ADC_A];
   assign act_adc_b  = act_vec[REG_ADC_B];

endmodule

// File: rtl/pwm_reload_chk.sv
module pwm_reload_chk
   import pwm_reload_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           wr_en,
   input logic [ADDR_W-1:0]              wr_addr,
   input logic [DATA_W-1:0]              wr_data,
   input logic                           imm_mode,
   input logic                           cull_en,
   input logic [NUM_BUF-1:0][DATA_W-1:0] shadow_vec,
   input logic [NUM_BUF-1:0][DATA_W-1:0] act_vec,
   input logic                           crest,
   input logic                           valley,
   input logic                           cnt_down,
   input logic                           cull_evt,
   input logic                           xfer,
   input logic                           armed
);

   AST_IMM_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      imm_mode && wr_en && wr_addr == ADDR_W'(REG_DUTY_V) |=> act_vec[REG_DUTY_V] == $past(wr_data)); // R2

   AST_XFER_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |-> (crest || valley)); // R4

   AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> act_vec == $past(shadow_vec)); // R4

   AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !imm_mode && !armed |=> $stable(act_vec)); // R5

   AST_CREST_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      crest && !valley |=> cnt_down); // R6

   AST_VALLEY_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      valley |=> !cnt_down); // R6

   AST_CULL_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      cull_evt |-> (crest || valley)); // R7

   AST_CULLED_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      !imm_mode && cull_en && xfer |-> cull_evt); // R8

   AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      xfer && wr_en && wr_addr == ADDR_W'(REG_DUTY_U) |=> armed); // R9

   AST_IMM_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      imm_mode |=> !armed); // R10

endmodule

bind pwm_reload_ctrl pwm_reload_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .imm_mode   (imm_q),
   .cull_en    (cull_en_q),
   .shadow_vec (shadow_vec),
   .act_vec    (act_vec),
   .crest      (crest),
   .valley     (valley),
   .cnt_down   (cnt_down),
   .cull_evt   (cull_evt),
   .xfer       (xfer),
   .armed      (armed)
);

// File: tb/tb_pwm_reload_ctrl.sv
module tb_pwm_reload_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [15:0] act_period, act_duty_u, act_duty_v, act_duty_w, act_cull, act_adc_a, act_adc_b;
   logic [15:0] cnt_value;
   logic        cnt_down, crest, valley, cull_evt, xfer, armed;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   pwm_reload_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .act_period(act_period), .act_duty_u(act_duty_u), .act_duty_v(act_duty_v),
      .act_duty_w(act_duty_w), .act_cull(act_cull), .act_adc_a(act_adc_a), .act_adc_b(act_adc_b),
      .cnt_value(cnt_value), .cnt_down(cnt_down), .crest(crest), .valley(valley),
      .cull_evt(cull_evt), .xfer(xfer), .armed(armed)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wait_evt(input string req);
      int n = 0;
      do begin @(negedge clk); n++; end while (!(crest || valley) && n < 200);
      if (!(crest || valley)) chk({req, " event timeout"}, 0, 1);
   endtask

   task automatic wait_xfer(input string req);
      int n = 0;
      do begin @(negedge clk); n++; end while (!xfer && n < 200);
      if (!xfer) chk({req, " transfer timeout"}, 0, 1);
   endtask

   task automatic t_reset;
      logic [15:0] d;
      chk("R1 counter start", cnt_value, 16'h0001);
      chk("R1 direction up", cnt_down, 1'b0);
      chk("R1 act period", act_period, 16'hFFFF);
      chk("R1 act duty u", act_duty_u, 16'h0000);
      chk("R1 act adc b", act_adc_b, 16'h0000);
      rd(3'd0, d); chk("R1 shadow period", d, 16'hFFFF);
      rd(3'd3, d); chk("R1 shadow duty w", d, 16'h0000);
      rd(3'd7, d); chk("R1 mode immediate", d, 16'h0001);
   endtask

   task automatic t_immediate;
      logic [15:0] d;
      wr(3'd0, 16'd6);
      chk("R2 period immediate", act_period, 16'd6);
      wr(3'd7, 16'h0003);
      rd(3'd7, d); chk("R3 mode readback", d, 16'h0003);
      wr(3'd2, 16'h1234);
      chk("R2 duty v immediate with cull bit", act_duty_v, 16'h1234);
      rd(3'd2, d); chk("R3 shadow v read", d, 16'h1234);
   endtask

   task automatic t_counter;
      logic [15:0] m;
      logic        dn;
      int n = 0;
      do begin @(negedge clk); n++; end while (!valley && n < 200);
      chk("R6 valley at 0001", cnt_value, 16'h0001);
      m = 16'd1; dn = 1'b0;
      for (int i = 0; i < 10; i++) begin
         if (m == 16'd6) begin m = m - 1; dn = 1'b1; end
         else if (m == 16'd1) begin m = m + 1; dn = 1'b0; end
         else m = dn ? m - 1 : m + 1;
         @(negedge clk);
         chk("R6 count value", cnt_value, m);
         chk("R6 direction", cnt_down, dn);
         chk("R6 crest flag", crest, (m == 16'd6));
      end
      chk("R6 valley at end", valley, 1'b1);
   endtask

   task automatic t_batch;
      logic [15:0] d;
      logic        saw;
      wr(3'd7, 16'h0000);
      wr(3'd2, 16'h3333);
      saw = 1'b0;
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         if (xfer) saw = 1'b1;
      end
      chk("R5 no transfer unarmed", saw, 1'b0);
      chk("R5 act v held", act_duty_v, 16'h1234);
      rd(3'd2, d); chk("R3 read returns shadow", d, 16'h3333);
      wr(3'd3, 16'h4444);
      wr(3'd5, 16'h00A1);
      wr(3'd6, 16'h00B2);
      wr(3'd1, 16'h2222);
      chk("R4 armed after u write", armed, 1'b1);
      wait_xfer("R4");
      chk("R4 transfer at crest or valley", crest || valley, 1'b1);
      chk("R4 u not yet active", act_duty_u, 16'h0000);
      @(negedge clk);
      chk("R4 act u", act_duty_u, 16'h2222);
      chk("R4 act v", act_duty_v, 16'h3333);
      chk("R4 act w", act_duty_w, 16'h4444);
      chk("R4 act adc a", act_adc_a, 16'h00A1);
      chk("R4 act adc b", act_adc_b, 16'h00B2);
      chk("R4 act period", act_period, 16'd6);
      chk("R4 disarmed", armed, 1'b0);
   endtask

   task automatic t_collide;
      wr(3'd1, 16'h4444);
      wait_xfer("R9 first");
      wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h5555;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R9 transfer took old value", act_duty_u, 16'h4444);
      chk("R9 stays armed", armed, 1'b1);
      wait_xfer("R9 second");
      @(negedge clk);
      chk("R9 new value at next point", act_duty_u, 16'h5555);
      chk("R9 disarmed after second", armed, 1'b0);
   endtask

   task automatic t_cull;
      int n;
      wr(3'd7, 16'h0002);
      wr(3'd4, 16'd2);
      wr(3'd1, 16'h6000);
      wait_xfer("R8 ratio zero");
      @(negedge clk);
      chk("R8 act cull loaded", act_cull, 16'd2);
      chk("R8 act u loaded", act_duty_u, 16'h6000);
      n = 0;
      do begin @(negedge clk); n++; end while (!cull_evt && n < 200);
      chk("R7 sync culled event", cull_evt, 1'b1);
      for (int k = 1; k <= 6; k++) begin
         wait_evt("R7");
         chk("R7 every third event", cull_evt, (k % 3 == 0));
      end
      wr(3'd1, 16'h7000);
      n = 0;
      for (int k = 0; k < 6; k++) begin
         wait_evt("R8");
         n++;
         if (cull_evt) begin
            chk("R8 transfer on culled event", xfer, 1'b1);
            break;
         end else begin
            chk("R8 no transfer on skipped event", xfer, 1'b0);
         end
      end
      chk("R8 third event transfers", n, 3);
      @(negedge clk);
      chk("R8 act u after culled transfer", act_duty_u, 16'h7000);
   endtask

   task automatic t_disarm;
      logic saw;
      wr(3'd1, 16'h8000);
      chk("R10 armed before switch", armed, 1'b1);
      wr(3'd7, 16'h0001);
      @(negedge clk);
      chk("R10 immediate clears arm", armed, 1'b0);
      wr(3'd7, 16'h0002);
      saw = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (xfer) saw = 1'b1;
      end
      chk("R10 no transfer after disarm", saw, 1'b0);
      chk("R10 act u kept", act_duty_u, 16'h7000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_immediate();
      t_counter();
      t_batch();
      t_collide();
      t_cull();
      t_disarm();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule